// File: doc/BRIEF.md
# Transfer Request Coalescer

This block keeps track of outstanding transfer requests while a transfer is running. Each request is a start address and a byte count. It holds one active descriptor, the one being drained, and at most one waiting descriptor. A request that continues exactly where a held descriptor ends is folded into that descriptor, so the count grows and no new slot is used. A request that does not continue either descriptor takes the waiting slot if it is free, and is refused if it is not. A downstream engine reports consumed bytes. When every byte of the active descriptor has been consumed, the waiting descriptor moves up, or the block goes idle if nothing is waiting.

Two more services come with the bookkeeping. A scheduling pulse returns the bytes of the active descriptor that have not yet been handed out, so a count-limited engine can be reloaded. A lookup port answers, one cycle later, whether a given address still lies in pending data. Within one clock the block applies consumption first, then promotion or retirement, then scheduling, and the incoming request last.

Top module: `xfer_coalescer`

## Requirements
- R1: While idle, a request with a non-zero count becomes the active descriptor with zero consumed and zero scheduled bytes, and the response code is 1 (started).
- R2: With the waiting slot empty, a request whose address equals active base plus active count (modulo the address width) adds its count to the active count, and the response code is 2.
- R3: A request whose address equals waiting base plus waiting count adds its count to the waiting count, and the response code is 3.
- R4: A request that continues neither descriptor, arriving while the waiting slot is empty, fills the waiting slot, and the response code is 4.
- R5: A request that continues neither descriptor, arriving while the waiting slot is full, changes no state, and the response code is 5.
- R6: Consumption is clamped to the bytes left in the active descriptor. When it reaches the active count and a descriptor is waiting, that descriptor becomes active with zero consumed and zero scheduled bytes, the waiting slot empties, and `promote` pulses for one cycle.
- R7: When consumption reaches the active count and nothing is waiting, the block goes idle and clears all descriptor fields to zero.
- R8: A promotion and a request in the same cycle are resolved with promotion first. The request is judged against the promoted descriptor and the now-empty waiting slot.
- R9: `qry_pend`, one cycle after `qry_addr` is presented, is 1 when the address lies in the active range from the consumed point up to its end, or anywhere in the waiting range. It is 0 while idle.
- R10: A `sched_take` pulse returns, in `sched_len` on the next cycle, the active count minus the bytes already scheduled, and marks the whole active count as scheduled. While idle it returns 0.
- R11: A request with a zero count changes nothing and gets response code 6. Consumption reported while idle changes nothing.
- R12: A merge whose sum would exceed the count width is not made. The request is then handled as non-contiguous.
- R13: Synchronous reset leaves the block idle with an empty waiting slot, zero descriptor fields, response code 0, `sched_len` 0, `promote` 0 and `qry_pend` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_vld | input | 1 | New request present this cycle |
| req_addr | input | AW | Request start address |
| req_len | input | CW | Request byte count |
| req_resp | output | 3 | Registered outcome of the last cycle's request: 0 none, 1 started, 2 merged active, 3 merged waiting, 4 queued, 5 refused, 6 ignored |
| cons_vld | input | 1 | Consumption report present |
| cons_len | input | CW | Bytes consumed from the active descriptor |
| sched_take | input | 1 | Request the unscheduled byte count |
| sched_len | output | CW | Bytes granted by the last scheduling pulse |
| promote | output | 1 | One-cycle pulse after a promotion |
| idle | output | 1 | No active descriptor |
| act_base | output | AW | Active descriptor start address |
| act_len | output | CW | Active descriptor byte count |
| act_done | output | CW | Bytes consumed from the active descriptor |
| que_vld | output | 1 | Waiting slot occupied |
| que_base | output | AW | Waiting descriptor start address |
| que_len | output | CW | Waiting descriptor byte count |
| qry_addr | input | AW | Address to look up |
| qry_pend | output | 1 | Registered lookup result |

## Verification
The bench builds the block with an 8-bit address and a 6-bit count. With these widths a request near the top of the address space wraps through zero, and a merge can reach the 63-byte count limit in a few steps. Both the wrapped-range lookups and the refused-merge case of R12 are therefore covered by short vectors. The small widths also keep every expected response and field value easy to work out by hand.

// File: rtl/xc_pkg.sv
package xc_pkg;

  typedef enum logic [2:0] {
    RSP_NONE    = 3'd0,
    RSP_START   = 3'd1,
    RSP_MRG_ACT = 3'd2,
    RSP_MRG_QUE = 3'd3,
    RSP_QUEUED  = 3'd4,
    RSP_REFUSE  = 3'd5,
    RSP_IGNORE  = 3'd6
  } rsp_e;

  localparam int unsigned N_SPANS = 2;

endpackage

// File: rtl/xc_slots.sv
module xc_slots
  import xc_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned CW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_vld,
  input  logic [AW-1:0] req_addr,
  input  logic [CW-1:0] req_len,
  input  logic          cons_vld,
  input  logic [CW-1:0] cons_len,
  output logic          a_on,
  output logic [AW-1:0] a_base,
  output logic [CW-1:0] a_len,
  output logic [CW-1:0] a_done,
  output logic          q_on,
  output logic [AW-1:0] q_base,
  output logic [CW-1:0] q_len,
  output rsp_e          resp,
  output logic          promote,
  output logic          run_mid,
  output logic [CW-1:0] len_mid,
  output logic          clr_mid
);

  // stage 1: consumption
  logic [CW-1:0] room, step, done1;
  logic          fin;
  // stage 2: promotion or retirement
  logic          prom, on2, qon2;
  logic [AW-1:0] base2, qbase2;
  logic [CW-1:0] len2, done2, qlen2;
  // stage 3: request
  logic [AW-1:0] end_a, end_q;
  logic [CW:0]   sum_a, sum_q;
  logic          fit_a, fit_q, cont_a, cont_q;
  logic          on3, qon3;
  logic [AW-1:0] base3, qbase3;
  logic [CW-1:0] len3, done3, qlen3;
  rsp_e          rsp3;

  always_comb begin
    room  = a_len - a_done;
    step  = '0;
    if (cons_vld && a_on) step = (cons_len > room) ? room : cons_len;
    done1 = a_done + step;
    fin   = a_on && (done1 == a_len);
  end

  always_comb begin
    prom   = fin && q_on;
    on2    = a_on && !(fin && !q_on);
    qon2   = q_on && !prom;
    base2  = prom ? q_base : (on2 ? a_base : '0);
    len2   = prom ? q_len  : (on2 ? a_len  : '0);
    done2  = (prom || !on2) ? '0 : done1;
    qbase2 = qon2 ? q_base : '0;
    qlen2  = qon2 ? q_len  : '0;
  end

  assign run_mid = on2;
  assign len_mid = len2;
  assign clr_mid = prom || !on2;

  always_comb begin
    end_a  = base2 + AW'(len2);
    end_q  = qbase2 + AW'(qlen2);
    sum_a  = {1'b0, len2} + {1'b0, req_len};
    sum_q  = {1'b0, qlen2} + {1'b0, req_len};
    fit_a  = !sum_a[CW];
    fit_q  = !sum_q[CW];
    cont_a = !qon2 && (req_addr == end_a) && fit_a;
    cont_q = qon2 && (req_addr == end_q) && fit_q;

    on3 = on2;  base3 = base2;  len3 = len2;  done3 = done2;
    qon3 = qon2; qbase3 = qbase2; qlen3 = qlen2;
    rsp3 = RSP_NONE;
    if (req_vld) begin
      if (req_len == '0) begin
        rsp3 = RSP_IGNORE;
      end else if (!on2) begin
        on3 = 1'b1; base3 = req_addr; len3 = req_len; done3 = '0;
        rsp3 = RSP_START;
      end else if (cont_a) begin
        len3 = sum_a[CW-1:0];
        rsp3 = RSP_MRG_ACT;
      end else if (cont_q) begin
        qlen3 = sum_q[CW-1:0];
        rsp3 = RSP_MRG_QUE;
      end else if (!qon2) begin
        qon3 = 1'b1; qbase3 = req_addr; qlen3 = req_len;
        rsp3 = RSP_QUEUED;
      end else begin
        rsp3 = RSP_REFUSE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      a_on <= 1'b0; a_base <= '0; a_len <= '0; a_done <= '0;
      q_on <= 1'b0; q_base <= '0; q_len <= '0;
      resp <= RSP_NONE; promote <= 1'b0;
    end else begin
      a_on <= on3; a_base <= base3; a_len <= len3; a_done <= done3;
      q_on <= qon3; q_base <= qbase3; q_len <= qlen3;
      resp <= rsp3; promote <= prom;
    end
  end

endmodule

// File: rtl/xc_sched.sv
module xc_sched #(
  parameter int unsigned CW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          take,
  input  logic          run_mid,
  input  logic [CW-1:0] len_mid,
  input  logic          clr_mid,
  output logic [CW-1:0] sched_len
);

  logic [CW-1:0] given, base_cnt, grant;

  always_comb begin
    base_cnt = clr_mid ? '0 : given;
    grant    = run_mid ? (len_mid - base_cnt) : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      given     <= '0;
      sched_len <= '0;
    end else begin
      if (take && run_mid) given <= len_mid;
      else                 given <= base_cnt;
      if (take) sched_len <= grant;
    end
  end

endmodule

// File: rtl/xc_span.sv
module xc_span #(
  parameter int unsigned AW = 16,
  parameter int unsigned CW = 12
) (
  input  logic          on,
  input  logic [AW-1:0] base,
  input  logic [CW-1:0] lo,
  input  logic [CW-1:0] hi,
  input  logic [AW-1:0] addr,
  output logic          hit
);

  logic [AW-1:0] off;

  always_comb begin
    off = addr - base;
    hit = on && (off >= AW'(lo)) && (off < AW'(hi));
  end

endmodule

// File: rtl/xfer_coalescer.sv
module xfer_coalescer
  import xc_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned CW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_vld,
  input  logic [AW-1:0] req_addr,
  input  logic [CW-1:0] req_len,
  output logic [2:0]    req_resp,
  input  logic          cons_vld,
  input  logic [CW-1:0] cons_len,
  input  logic          sched_take,
  output logic [CW-1:0] sched_len,
  output logic          promote,
  output logic          idle,
  output logic [AW-1:0] act_base,
  output logic [CW-1:0] act_len,
  output logic [CW-1:0] act_done,
  output logic          que_vld,
  output logic [AW-1:0] que_base,
  output logic [CW-1:0] que_len,
  input  logic [AW-1:0] qry_addr,
  output logic          qry_pend
);

  logic          a_on, run_mid, clr_mid;
  logic [CW-1:0] len_mid;
  rsp_e          resp;

  xc_slots #(.AW(AW), .CW(CW)) u_slots (
    .clk(clk), .rst(rst),
    .req_vld(req_vld), .req_addr(req_addr), .req_len(req_len),
    .cons_vld(cons_vld), .cons_len(cons_len),
    .a_on(a_on), .a_base(act_base), .a_len(act_len), .a_done(act_done),
    .q_on(que_vld), .q_base(que_base), .q_len(que_len),
    .resp(resp), .promote(promote),
    .run_mid(run_mid), .len_mid(len_mid), .clr_mid(clr_mid)
  );

  xc_sched #(.CW(CW)) u_sched (
    .clk(clk), .rst(rst), .take(sched_take),
    .run_mid(run_mid), .len_mid(len_mid), .clr_mid(clr_mid),
    .sched_len(sched_len)
  );

  assign req_resp = resp;
  assign idle     = !a_on;

  logic          sp_on   [N_SPANS];
  logic [AW-1:0] sp_base [N_SPANS];
  logic [CW-1:0] sp_lo   [N_SPANS];
  logic [CW-1:0] sp_hi   [N_SPANS];
  logic [N_SPANS-1:0] sp_hit;

  always_comb begin
    sp_on[0] = a_on;    sp_base[0] = act_base; sp_lo[0] = act_done; sp_hi[0] = act_len;
    sp_on[1] = que_vld; sp_base[1] = que_base; sp_lo[1] = '0;       sp_hi[1] = que_len;
  end

  for (genvar g = 0; g < N_SPANS; g++) begin : g_span
    xc_span #(.AW(AW), .CW(CW)) u_span (
      .on(sp_on[g]), .base(sp_base[g]), .lo(sp_lo[g]), .hi(sp_hi[g]),
      .addr(qry_addr), .hit(sp_hit[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) qry_pend <= 1'b0;
    else     qry_pend <= |sp_hit;
  end

endmodule

// File: rtl/xc_chk.sv
module xc_chk #(
  parameter int unsigned AW = 16,
  parameter int unsigned CW = 12
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] req_addr,
  input logic [CW-1:0] req_len,
  input logic [2:0]    req_resp,
  input logic          promote,
  input logic          idle,
  input logic [AW-1:0] act_base,
  input logic [CW-1:0] act_len,
  input logic [CW-1:0] act_done,
  input logic          que_vld,
  input logic [AW-1:0] que_base,
  input logic          qry_pend
);

  assert_start_fresh_R1: assert property (@(posedge clk) disable iff (rst)
    req_resp == 3'd1 |-> act_done == '0 && act_len == $past(req_len) && act_base == $past(req_addr));

  assert_queue_needs_active_R4: assert property (@(posedge clk) disable iff (rst)
    que_vld |-> !idle);

  assert_refuse_keeps_slot_R5: assert property (@(posedge clk) disable iff (rst)
    req_resp == 3'd5 |-> que_vld && $stable(que_base));

  assert_done_below_len_R6: assert property (@(posedge clk) disable iff (rst)
    !idle |-> act_done < act_len);

  assert_promote_moves_slot_R6: assert property (@(posedge clk) disable iff (rst)
    promote |-> act_base == $past(que_base) && act_done == '0 && $past(que_vld));

  assert_idle_no_pending_R9: assert property (@(posedge clk) disable iff (rst)
    $past(idle) |-> !qry_pend);

  assert_zero_ignored_R11: assert property (@(posedge clk) disable iff (rst)
    req_resp == 3'd6 |-> $past(req_len) == '0);

endmodule

bind xfer_coalescer xc_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .req_addr(req_addr), .req_len(req_len),
  .req_resp(req_resp), .promote(promote), .idle(idle),
  .act_base(act_base), .act_len(act_len), .act_done(act_done),
  .que_vld(que_vld), .que_base(que_base), .qry_pend(qry_pend)
);

// File: tb/test_xfer_coalescer.sv
`timescale 1ns/1ps
module test_xfer_coalescer;

  localparam int unsigned AW = 8;
  localparam int unsigned CW = 6;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_vld = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [CW-1:0] req_len = '0;
  logic [2:0]    req_resp;
  logic          cons_vld = 1'b0;
  logic [CW-1:0] cons_len = '0;
  logic          sched_take = 1'b0;
  logic [CW-1:0] sched_len;
  logic          promote, idle, que_vld, qry_pend;
  logic [AW-1:0] act_base, que_base;
  logic [AW-1:0] qry_addr = '0;
  logic [CW-1:0] act_len, act_done, que_len;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  xfer_coalescer #(.AW(AW), .CW(CW)) i_xfer_coalescer (
    .clk(clk), .rst(rst),
    .req_vld(req_vld), .req_addr(req_addr), .req_len(req_len), .req_resp(req_resp),
    .cons_vld(cons_vld), .cons_len(cons_len),
    .sched_take(sched_take), .sched_len(sched_len),
    .promote(promote), .idle(idle),
    .act_base(act_base), .act_len(act_len), .act_done(act_done),
    .que_vld(que_vld), .que_base(que_base), .que_len(que_len),
    .qry_addr(qry_addr), .qry_pend(qry_pend)
  );

  // op: 0 request (expect response code), 1 consume (expect {act_base,2'b0,act_done}),
  //     2 lookup (expect qry_pend), 3 schedule (expect sched_len)
  localparam int NV = 28;
  localparam logic [31:0] VEC [NV] = '{
    {2'd0, 8'h10, 6'd8,  16'd1},      // R1 start
    {2'd0, 8'h18, 6'd4,  16'd2},      // R2 merge active
    {2'd0, 8'h40, 6'd5,  16'd4},      // R4 queue
    {2'd0, 8'h45, 6'd3,  16'd3},      // R3 merge waiting
    {2'd0, 8'h1C, 6'd2,  16'd5},      // R5 active-contiguous but slot full
    {2'd0, 8'h80, 6'd1,  16'd5},      // R5
    {2'd2, 8'h10, 6'd0,  16'd1},      // R9
    {2'd2, 8'h1B, 6'd0,  16'd1},
    {2'd2, 8'h1C, 6'd0,  16'd0},
    {2'd2, 8'h47, 6'd0,  16'd1},
    {2'd2, 8'h48, 6'd0,  16'd0},
    {2'd2, 8'h3F, 6'd0,  16'd0},
    {2'd1, 8'h00, 6'd4,  16'h1004},   // R6 partial consume
    {2'd2, 8'h13, 6'd0,  16'd0},      // R9 below consumed point
    {2'd2, 8'h14, 6'd0,  16'd1},
    {2'd3, 8'h00, 6'd0,  16'd12},     // R10
    {2'd3, 8'h00, 6'd0,  16'd0},      // R10 nothing left
    {2'd1, 8'h00, 6'd20, 16'h4000},   // R6 clamp and promote
    {2'd0, 8'h48, 6'd8,  16'd2},      // R2 after promotion
    {2'd3, 8'h00, 6'd0,  16'd16},     // R10 counter reset on promote
    {2'd1, 8'h00, 6'd16, 16'h0000},   // R7 retire to idle
    {2'd2, 8'h48, 6'd0,  16'd0},      // R9 idle
    {2'd0, 8'hFC, 6'd8,  16'd1},      // R1 wrapping range
    {2'd2, 8'h02, 6'd0,  16'd1},      // R9 wrapped
    {2'd2, 8'h04, 6'd0,  16'd0},
    {2'd0, 8'h04, 6'd60, 16'd4},      // R12 overflow refuses merge
    {2'd0, 8'h40, 6'd0,  16'd6},      // R11 zero count
    {2'd2, 8'h3F, 6'd0,  16'd1}       // R9 waiting range
  };

  task automatic check(input string rq, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    req_vld = 1'b0; cons_vld = 1'b0; sched_take = 1'b0;
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R13 idle", int'(idle), 1);
    check("R13 resp", int'(req_resp), 0);
    check("R13 queue", int'(que_vld), 0);
    check("R13 sched", int'(sched_len), 0);

    for (int i = 0; i < NV; i++) begin
      logic [1:0] op;
      logic [15:0] e;
      op = VEC[i][31:30];
      e  = VEC[i][15:0];
      case (op)
        2'd0: begin req_vld = 1'b1; req_addr = VEC[i][29:22]; req_len = VEC[i][21:16]; end
        2'd1: begin cons_vld = 1'b1; cons_len = VEC[i][21:16]; end
        2'd2: qry_addr = VEC[i][29:22];
        default: sched_take = 1'b1;
      endcase
      step();
      case (op)
        2'd0: check($sformatf("vec%0d R1-R5/R11/R12 response", i), int'(req_resp), int'(e));
        2'd1: check($sformatf("vec%0d R6/R7 consume", i), int'({act_base, 2'b00, act_done}), int'(e));
        2'd2: check($sformatf("vec%0d R9 lookup", i), int'(qry_pend), int'(e));
        default: check($sformatf("vec%0d R10 schedule", i), int'(sched_len), int'(e));
      endcase
    end

    // R8: active FC/8 fully consumed while a request continues the waiting 04/60
    cons_vld = 1'b1; cons_len = 6'd8;
    req_vld = 1'b1; req_addr = 8'h40; req_len = 6'd2;
    step();
    check("R8 promote", int'(promote), 1);
    check("R8 resp", int'(req_resp), 2);
    check("R8 base", int'(act_base), 'h04);
    check("R8 len", int'(act_len), 62);
    check("R8 slot empty", int'(que_vld), 0);
    step();
    check("R6 promote pulse", int'(promote), 0);

    req_vld = 1'b1; req_addr = 8'h42; req_len = 6'd2;
    step();
    check("R12 resp", int'(req_resp), 4);
    check("R12 slot len", int'(que_len), 2);

    cons_vld = 1'b1; cons_len = 6'd62;
    step();
    check("R6 base", int'(act_base), 'h42);
    check("R6 len", int'(act_len), 2);

    cons_vld = 1'b1; cons_len = 6'd2;
    step();
    check("R7 idle", int'(idle), 1);

    cons_vld = 1'b1; cons_len = 6'd5;
    step();
    check("R11 idle consume done", int'(act_done), 0);
    check("R11 idle kept", int'(idle), 1);

    req_vld = 1'b1; req_addr = 8'h20; req_len = 6'd3;
    step();
    check("R1 start", int'(idle), 0);
    rst = 1'b1;
    step();
    rst = 1'b0;
    check("R13 idle after reset", int'(idle), 1);
    check("R13 len after reset", int'(act_len), 0);
    check("R13 qry after reset", int'(qry_pend), 0);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule